// File: doc/BRIEF.md
# Watchdog Timer with Shaped Reset Output

This block is a watchdog peripheral behind a narrow byte-wide register port. Software programs an 8-bit timeout count and a control byte. The control byte selects whether counting runs, whether the count unit is a second or a minute, and how the reset output behaves. Once counting is enabled, the block counts down the programmed number of units. When the count runs out, it raises a sticky expiry flag and asserts its reset output. The output is either a level held until software reacts, or one pulse of a selectable fixed width. Its active polarity is also selectable.

Software keeps the system alive by rewriting the timeout count while the timer runs. Each such write reloads the countdown and restarts the unit timing from that write. A built-in prescaler divides the system clock into millisecond, second and minute ticks. The clock division and every duration are parameters, so a bench can shrink them in proportion.

Top module: `wdog_timer`

## Requirements
- R1: After reset, both registers read 0x00 and the reset output is high, because polarity 0 means the output is active low and idle high.
- R2: The control register is at offset `CFG_OFS` (5) and the timeout register is at offset `TMO_OFS` (6). The control fields read back as written: bit 5 enable, bit 4 pulse mode, bit 3 minute unit, bit 2 active-high polarity, bits 1:0 pulse-width select. Bit 7 always reads 0. Any other offset reads 0x00.
- R3: Control bit 6 is the expiry flag. Expiry sets it. Writing 1 to bit 6 of the control register clears it, and writing 0 there leaves it unchanged. If expiry and clear fall in the same cycle, the flag is set.
- R4: After the control write that sets the enable bit, expiry happens exactly N*U clock edges later. N is the timeout count. U is `CLK_PER_MS*MS_PER_SEC` cycles when bit 3 is 0, and that value times `SEC_PER_MIN` when bit 3 is 1.
- R5: A timeout count of 0 never expires.
- R6: Writing the timeout register while the timer is enabled loads the new count and restarts the unit timing. Expiry then follows N*U edges after that write.
- R7: Clearing the enable bit stops the count, reloads it from the timeout register and deasserts the reset output at once. Enabling again restarts the full timeout.
- R8: In level mode (bit 4 = 0), the output is asserted from the expiry edge until the flag is cleared or the timer is disabled.
- R9: In pulse mode (bit 4 = 1), the output is asserted for exactly `CLK_PER_MS` times PWn cycles after the expiry edge. PWn is selected by bits 1:0: 0 gives `PW0_MS` (1 ms), 1 gives `PW1_MS` (25 ms), 2 gives `PW2_MS` (125 ms) and 3 gives `PW3_MS` (5000 ms).
- R10: With polarity bit 2 = 1 the output is high while asserted. With bit 2 = 0 it is low while asserted and high otherwise.
- R11: After expiry the countdown stays stopped, so no second expiry or pulse occurs until the count is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| rst_out_o | output | 1 | Shaped watchdog reset output |

## Verification
The bound checker watches, on every cycle, four rules at the block's edge. The reserved control bit must read 0. The expiry flag must stay set until software clears it, and the clear must take effect. The output must go idle whenever the timer is disabled and must hold while a level-mode expiry is pending. The checker also confirms that one expiry never repeats on the next edge. Exact arithmetic timing needs the bench's scenarios, because it depends on the programmed history. This covers the edge of expiry for each unit and count, the pulse length for each width code, the restart after a reload or a re-enable, and the silence of a zero count. The bench sweeps every combination of mode, polarity, pulse width and unit over two counts.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W = 8;

    // control fields in the order they are packed into bits 5:0
    typedef struct packed {
        logic       en;
        logic       pulse_mode;
        logic       unit_min;
        logic       act_high;
        logic [1:0] pw_sel;
    } wdog_ctrl_t;

    localparam int CTRL_W    = $bits(wdog_ctrl_t);
    localparam int FLAG_BIT  = 6;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int CLK_PER_MS  = 100000,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic restart_i,
    output logic ms_tick_o,
    output logic sec_tick_o,
    output logic min_tick_o
);

    localparam int MS_W  = $clog2(CLK_PER_MS + 1);
    localparam int SEC_W = $clog2(MS_PER_SEC + 1);
    localparam int MIN_W = $clog2(SEC_PER_MIN + 1);

    typedef struct packed {
        logic [MS_W-1:0]  ms_cnt;
        logic [SEC_W-1:0] sec_cnt;
        logic [MIN_W-1:0] min_cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic ms_tick, sec_tick, min_tick;

    always_comb begin
        ms_tick  = run_i && (st_q.ms_cnt == MS_W'(CLK_PER_MS - 1));
        sec_tick = ms_tick && (st_q.sec_cnt == SEC_W'(MS_PER_SEC - 1));
        min_tick = sec_tick && (st_q.min_cnt == MIN_W'(SEC_PER_MIN - 1));

        st_d = st_q;
        if (!run_i || restart_i) begin
            st_d = '0;
        end else if (ms_tick) begin
            st_d.ms_cnt = '0;
            if (sec_tick) begin
                st_d.sec_cnt = '0;
                st_d.min_cnt = min_tick ? '0 : st_q.min_cnt + 1'b1;
            end else begin
                st_d.sec_cnt = st_q.sec_cnt + 1'b1;
            end
        end else begin
            st_d.ms_cnt = st_q.ms_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ms_tick_o  = ms_tick;
    assign sec_tick_o = sec_tick;
    assign min_tick_o = min_tick;

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int CFG_OFS = 5,
    parameter int TMO_OFS = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              expire_i,
    output wdog_ctrl_t        ctrl_o,
    output logic [DATA_W-1:0] tmo_o,
    output logic              flag_o,
    output logic              tmo_wr_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        wdog_ctrl_t        ctrl;
        logic [DATA_W-1:0] tmo;
        logic              flag;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic cfg_hit, tmo_hit;

    always_comb begin
        cfg_hit = wr_en_i && (addr_i == ADDR_W'(CFG_OFS));
        tmo_hit = wr_en_i && (addr_i == ADDR_W'(TMO_OFS));

        st_d = st_q;
        if (cfg_hit) begin
            st_d.ctrl = wdog_ctrl_t'(wdata_i[CTRL_W-1:0]);
            if (wdata_i[FLAG_BIT]) st_d.flag = 1'b0;
        end
        if (tmo_hit) st_d.tmo = wdata_i;
        // a fresh expiry wins over a simultaneous clear
        if (expire_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(CFG_OFS))      rdata_o = {1'b0, st_q.flag, st_q.ctrl};
        else if (addr_i == ADDR_W'(TMO_OFS)) rdata_o = st_q.tmo;
    end

    assign ctrl_o   = st_q.ctrl;
    assign tmo_o    = st_q.tmo;
    assign flag_o   = st_q.flag;
    assign tmo_wr_o = tmo_hit;

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              unit_tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic [DATA_W-1:0] tmo_i,
    output logic              expire_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rem;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (!en_i) begin
            st_d.rem = load_i ? load_val_i : tmo_i;
        end else if (load_i) begin
            st_d.rem = load_val_i;
        end else if (unit_tick_i && (st_q.rem != '0)) begin
            st_d.rem = st_q.rem - 1'b1;
            expire_o = (st_q.rem == DATA_W'(1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/wdog_outshape.sv
module wdog_outshape #(
    parameter int PW0_MS = 1,
    parameter int PW1_MS = 25,
    parameter int PW2_MS = 125,
    parameter int PW3_MS = 5000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       pulse_mode_i,
    input  logic       act_high_i,
    input  logic [1:0] pw_sel_i,
    input  logic       flag_i,
    input  logic       expire_i,
    input  logic       ms_tick_i,
    output logic       rst_out_o
);

    localparam int PW_A   = (PW0_MS > PW1_MS) ? PW0_MS : PW1_MS;
    localparam int PW_B   = (PW2_MS > PW3_MS) ? PW2_MS : PW3_MS;
    localparam int PW_MAX = (PW_A > PW_B) ? PW_A : PW_B;
    localparam int PW_W   = $clog2(PW_MAX + 1);

    typedef struct packed {
        logic            on;
        logic [PW_W-1:0] cnt;
    } pls_state_t;

    pls_state_t st_d, st_q;
    logic [PW_W-1:0] last_cnt;
    logic active;

    always_comb begin
        case (pw_sel_i)
            2'd0:    last_cnt = PW_W'(PW0_MS - 1);
            2'd1:    last_cnt = PW_W'(PW1_MS - 1);
            2'd2:    last_cnt = PW_W'(PW2_MS - 1);
            default: last_cnt = PW_W'(PW3_MS - 1);
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (expire_i && pulse_mode_i) begin
            st_d.on  = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.on && ms_tick_i) begin
            if (st_q.cnt == last_cnt) begin
                st_d.on  = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        active    = en_i && (pulse_mode_i ? st_q.on : flag_i);
        rst_out_o = act_high_i ? active : !active;
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int CFG_OFS     = 5,
    parameter int TMO_OFS     = 6,
    parameter int CLK_PER_MS  = 100000,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_PER_MIN = 60,
    parameter int PW0_MS      = 1,
    parameter int PW1_MS      = 25,
    parameter int PW2_MS      = 125,
    parameter int PW3_MS      = 5000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              rst_out_o
);

    wdog_ctrl_t        ctrl;
    logic [DATA_W-1:0] tmo;
    logic              flag_w;
    logic              tmo_wr;
    logic              expire_w;
    logic              ms_tick, sec_tick, min_tick, unit_tick;
    logic              en_w, pulse_w, hi_w;

    assign en_w    = ctrl.en;
    assign pulse_w = ctrl.pulse_mode;
    assign hi_w    = ctrl.act_high;

    wdog_regs #(
        .ADDR_W (ADDR_W),
        .CFG_OFS(CFG_OFS),
        .TMO_OFS(TMO_OFS)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .expire_i(expire_w),
        .ctrl_o  (ctrl),
        .tmo_o   (tmo),
        .flag_o  (flag_w),
        .tmo_wr_o(tmo_wr),
        .rdata_o (rdata_o)
    );

    wdog_prescaler #(
        .CLK_PER_MS (CLK_PER_MS),
        .MS_PER_SEC (MS_PER_SEC),
        .SEC_PER_MIN(SEC_PER_MIN)
    ) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (en_w),
        .restart_i (tmo_wr),
        .ms_tick_o (ms_tick),
        .sec_tick_o(sec_tick),
        .min_tick_o(min_tick)
    );

    assign unit_tick = ctrl.unit_min ? min_tick : sec_tick;

    wdog_countdown u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_w),
        .unit_tick_i(unit_tick),
        .load_i     (tmo_wr),
        .load_val_i (wdata_i),
        .tmo_i      (tmo),
        .expire_o   (expire_w)
    );

    wdog_outshape #(
        .PW0_MS(PW0_MS),
        .PW1_MS(PW1_MS),
        .PW2_MS(PW2_MS),
        .PW3_MS(PW3_MS)
    ) u_out (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_w),
        .pulse_mode_i(pulse_w),
        .act_high_i  (hi_w),
        .pw_sel_i    (ctrl.pw_sel),
        .flag_i      (flag_w),
        .expire_i    (expire_w),
        .ms_tick_i   (ms_tick),
        .rst_out_o   (rst_out_o)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
    parameter int ADDR_W  = 3,
    parameter int CFG_OFS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic              rst_out,
    input logic              en,
    input logic              pulse_mode,
    input logic              act_high,
    input logic              flag,
    input logic              expire
);

    logic clr_wr;
    assign clr_wr = wr_en && (addr == ADDR_W'(CFG_OFS)) && wdata[6];

    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(CFG_OFS)) |-> !rdata[7]);

    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_wr) |=> flag);

    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !expire) |=> !flag);

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (rst_out == !act_high));

    assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !pulse_mode && flag) |-> (rst_out == act_high));

    assert_single_expiry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

endmodule

bind wdog_timer wdog_timer_chk #(
    .ADDR_W (ADDR_W),
    .CFG_OFS(CFG_OFS)
) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .wr_en     (wr_en_i),
    .addr      (addr_i),
    .wdata     (wdata_i),
    .rdata     (rdata_o),
    .rst_out   (rst_out_o),
    .en        (en_w),
    .pulse_mode(pulse_w),
    .act_high  (hi_w),
    .flag      (flag_w),
    .expire    (expire_w)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;

    localparam int CPM = 2;
    localparam int MPS = 10;
    localparam int SPM = 4;
    localparam int PW0 = 1;
    localparam int PW1 = 3;
    localparam int PW2 = 6;
    localparam int PW3 = 20;
    localparam int U_SEC = CPM * MPS;
    localparam int U_MIN = U_SEC * SPM;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rst_out;

    int vectors = 0;
    int misses = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wdog_timer #(
        .ADDR_W(3), .CFG_OFS(5), .TMO_OFS(6),
        .CLK_PER_MS(CPM), .MS_PER_SEC(MPS), .SEC_PER_MIN(SPM),
        .PW0_MS(PW0), .PW1_MS(PW1), .PW2_MS(PW2), .PW3_MS(PW3)
    ) u_wdog_timer (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .rst_out_o(rst_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    function automatic int pw_ms(input int sel);
        case (sel)
            0: return PW0;
            1: return PW1;
            2: return PW2;
            default: return PW3;
        endcase
    endfunction

    function automatic bit out_lvl(input bit act, input bit hi);
        return hi ? act : !act;
    endfunction

    // program, enable, then compare the output on every cycle
    task automatic run_case(input int tmo, input logic [7:0] cfg);
        int t, p, last;
        bit pm, hi, act;
        logic [7:0] d;
        pm = cfg[4]; hi = cfg[2];
        t = tmo * (cfg[3] ? U_MIN : U_SEC);
        p = CPM * pw_ms(int'(cfg[1:0]));
        last = pm ? t + p + 20 : t + 10;
        wr(3'd6, 8'(tmo));
        wr(3'd5, cfg);
        for (int k = 0; k <= last; k++) begin
            act = pm ? (k >= t && k < t + p) : (k >= t);
            chk($sformatf("R4/R8/R9/R10/R11 cfg=%0h k=%0d", cfg, k),
                int'(rst_out), int'(out_lvl(act, hi)));
            @(negedge clk);
        end
        rd(3'd5, d);
        chk("R2/R3 readback after expiry", int'(d), int'({2'b01, cfg[5:0]}));
        if (!pm) begin
            wr(3'd5, cfg & 8'hBF);
            chk("R3 writing 0 keeps flag", int'(rst_out), int'(out_lvl(1'b1, hi)));
            rd(3'd5, d);
            chk("R3 flag kept", int'(d[6]), 1);
            wr(3'd5, cfg | 8'h40);
            chk("R8 level drops on clear", int'(rst_out), int'(out_lvl(1'b0, hi)));
        end
        wr(3'd5, 8'h40);
        chk("R7 idle after disable", int'(rst_out), 1);
        rd(3'd5, d);
        chk("R3 flag cleared", int'(d), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(3'd5, d); chk("R1 cfg reset", int'(d), 0);
        rd(3'd6, d); chk("R1 tmo reset", int'(d), 0);
        chk("R1 output idle high", int'(rst_out), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: reserved bit, field readback, unmapped offset
        wr(3'd5, 8'h9F);
        rd(3'd5, d); chk("R2 bit7 reads 0 and fields read back", int'(d), 8'h1F);
        wr(3'd5, 8'h00);
        wr(3'd6, 8'hA5);
        rd(3'd6, d); chk("R2 timeout readback", int'(d), 8'hA5);
        rd(3'd3, d); chk("R2 unmapped offset", int'(d), 0);

        // R4 R9 R10: five units, active-low pulse, width code 2
        run_case(5, 8'h32);

        // sweep every mode, polarity, width and unit
        for (int pm = 0; pm < 2; pm++)
            for (int un = 0; un < 2; un++)
                for (int hi = 0; hi < 2; hi++)
                    for (int pw = 0; pw < 4; pw++)
                        for (int n = 1; n <= 3; n += 2)
                            run_case(n, 8'(32 + pm * 16 + un * 8 + hi * 4 + pw));

        // R5: zero count never expires
        wr(3'd6, 8'h00);
        wr(3'd5, 8'h24);
        for (int k = 0; k < 300; k++) begin
            chk("R5 zero count silent", int'(rst_out), 0);
            @(negedge clk);
        end
        rd(3'd5, d); chk("R5 no flag", int'(d[6]), 0);
        wr(3'd5, 8'h40);

        // R6: kick reloads and restarts the timing
        wr(3'd6, 8'd2);
        wr(3'd5, 8'h24);
        repeat (30) @(negedge clk);
        wr(3'd6, 8'd2);
        for (int k = 0; k <= 2 * U_SEC + 3; k++) begin
            chk($sformatf("R6 after kick k=%0d", k), int'(rst_out), int'(k >= 2 * U_SEC));
            @(negedge clk);
        end
        wr(3'd5, 8'h40);

        // R7: disabling mid-count restarts the full timeout
        wr(3'd6, 8'd2);
        wr(3'd5, 8'h24);
        repeat (30) @(negedge clk);
        wr(3'd5, 8'h04);
        repeat (50) @(negedge clk);
        chk("R7 disabled stays idle", int'(rst_out), 0);
        wr(3'd5, 8'h24);
        for (int k = 0; k <= 2 * U_SEC + 3; k++) begin
            chk($sformatf("R7 re-enable k=%0d", k), int'(rst_out), int'(k >= 2 * U_SEC));
            @(negedge clk);
        end
        wr(3'd5, 8'h40);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule